// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic and logic stage for an 8-bit accumulator machine. Each accepted request pairs the current accumulator value with an operand and the current flag nibble. It returns a new accumulator value, a strobe that says whether the accumulator should be written, and a new flag nibble. The operand is either a register value or an immediate byte, and a select input chooses between them.

Two request classes share the block. In a two-operand request, a 3-bit function index picks the operation: addition or subtraction (each with or without carry), a bitwise logic operation, or a compare that discards its result. A single-operand request instead acts on the accumulator or the carry flag. These requests cover the four one-bit rotates, the complement, and setting or inverting the carry.

Results are computed combinationally. They are captured in an output register on the clock edge that accepts the request, so every result becomes visible exactly one cycle after its request. Operand fetch, the register file and instruction sequencing belong to the surrounding core.

Top module: `acc_alu_unit`

## Requirements
- R1: A request presented with `inValid` high is captured on a rising edge, and its result appears on the outputs after that edge together with `outValid`. `outValid` is low after any edge on which `inValid` was low. An active-low reset clears `outValid`, `accOut`, `accWrEn` and `flagsOut` to zero.
- R2: When `isUnary` is 0, `funcSel` selects the operation: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 XOR, 6 OR, 7 compare. Functions 0 to 6 raise `accWrEn`.
- R3: Compare (`funcSel`=7) produces the same `accOut` difference and flags as subtract, but `accWrEn` stays 0.
- R4: Add-with-carry adds the operand and the incoming C flag to A. Subtract-with-borrow subtracts both the operand and the incoming C flag from A. Plain add, subtract and compare ignore the incoming C.
- R5: The flag nibble is ordered Z N H C, with Z in bit 3 and C in bit 0. For all eight functions, Z is 1 exactly when the 8-bit result is zero. N is 1 for subtract, subtract-with-borrow and compare, and 0 for the other functions.
- R6: For add, H is the carry out of bit 3 and C is the carry out of bit 7. For the subtract forms, H is the borrow from bit 4 and C is the borrow out of bit 7.
- R7: AND sets H to 1 and C to 0. XOR and OR set both H and C to 0.
- R8: When `useImm` is 1 the operand is `immOperand`; when it is 0 the operand is `regOperand`.
- R9: With `isUnary` 1, `unarySel` 0 rotates A left and `unarySel` 1 rotates A right. In both cases the bit shifted out wraps around to the other end and is also copied into C.
- R10: `unarySel` 2 rotates A left and `unarySel` 3 rotates A right, each through the carry. The incoming C enters the vacated bit and the bit shifted out goes to C. All four rotates clear Z, N and H and raise `accWrEn`.
- R11: `unarySel` 4 writes the bitwise inverse of A. It sets N and H and leaves Z and C unchanged.
- R12: `unarySel` 5 sets C and `unarySel` 6 inverts C. Both clear N and H, keep Z, and leave `accWrEn` at 0 with `accOut` equal to A.
- R13: `unarySel` 7 is a no-op: `accWrEn` is 0, `accOut` equals A and `flagsOut` equals the incoming flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present this cycle |
| isUnary | input | 1 | 1 selects a single-operand accumulator operation |
| funcSel | input | 3 | Two-operand function index |
| unarySel | input | 3 | Single-operand operation code |
| useImm | input | 1 | 1 takes the immediate byte as operand |
| accIn | input | DATA_W | Current accumulator value |
| regOperand | input | DATA_W | Register operand |
| immOperand | input | DATA_W | Immediate operand |
| flagsIn | input | 4 | Current flags {Z,N,H,C} |
| outValid | output | 1 | Result registered this cycle |
| accOut | output | DATA_W | Computed accumulator value |
| accWrEn | output | 1 | Accumulator write strobe |
| flagsOut | output | 4 | New flags {Z,N,H,C} |

## Verification
The bench builds the block only with its default `DATA_W` of 8, so the 4-bit half-carry boundary and the 8-bit wrap are the ones the requirements name. At that width, operands such as 0x0F, 0x10, 0x80 and 0xFF reach every H and C transition, for both carries and borrows. They also cover carry-in reaching the top bit and rotates moving bits between bit 7, bit 0 and C. A sweep of sample operand pairs runs all eight functions with the carry both set and clear.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int FLAG_Z = 3;
  localparam int FLAG_N = 2;
  localparam int FLAG_H = 1;
  localparam int FLAG_C = 0;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_ADC = 3'd1,
    FN_SUB = 3'd2,
    FN_SBC = 3'd3,
    FN_AND = 3'd4,
    FN_XOR = 3'd5,
    FN_OR  = 3'd6,
    FN_CP  = 3'd7
  } aluFunc_t;

  typedef enum logic [2:0] {
    UN_ROL  = 3'd0,
    UN_ROR  = 3'd1,
    UN_ROLC = 3'd2,
    UN_RORC = 3'd3,
    UN_INV  = 3'd4,
    UN_SETC = 3'd5,
    UN_FLPC = 3'd6,
    UN_NOP  = 3'd7
  } unaryOp_t;

  typedef struct packed {
    logic arith;
    logic subtract;
    logic carryIn;
    logic logicAnd;
    logic logicXor;
    logic logicOr;
    logic writeAcc;
    logic rotate;
    logic rotLeft;
    logic rotThru;
    logic complement;
    logic setCarry;
    logic flipCarry;
  } aluStrobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic       isUnary,
  input  logic [2:0] funcSel,
  input  logic [2:0] unarySel,
  output aluStrobe_t strobe
);

  aluFunc_t fnCode;
  unaryOp_t unCode;

  assign fnCode = aluFunc_t'(funcSel);
  assign unCode = unaryOp_t'(unarySel);

  always_comb begin
    strobe = '0;
    if (!isUnary) begin
      unique case (fnCode)
        FN_ADD: begin strobe.arith = 1'b1; strobe.writeAcc = 1'b1; end
        FN_ADC: begin strobe.arith = 1'b1; strobe.carryIn = 1'b1; strobe.writeAcc = 1'b1; end
        FN_SUB: begin strobe.arith = 1'b1; strobe.subtract = 1'b1; strobe.writeAcc = 1'b1; end
        FN_SBC: begin
          strobe.arith    = 1'b1;
          strobe.subtract = 1'b1;
          strobe.carryIn  = 1'b1;
          strobe.writeAcc = 1'b1;
        end
        FN_AND: begin strobe.logicAnd = 1'b1; strobe.writeAcc = 1'b1; end
        FN_XOR: begin strobe.logicXor = 1'b1; strobe.writeAcc = 1'b1; end
        FN_OR:  begin strobe.logicOr = 1'b1; strobe.writeAcc = 1'b1; end
        FN_CP:  begin strobe.arith = 1'b1; strobe.subtract = 1'b1; end
        default: strobe = '0;
      endcase
    end else begin
      unique case (unCode)
        UN_ROL:  begin strobe.rotate = 1'b1; strobe.rotLeft = 1'b1; strobe.writeAcc = 1'b1; end
        UN_ROR:  begin strobe.rotate = 1'b1; strobe.writeAcc = 1'b1; end
        UN_ROLC: begin
          strobe.rotate   = 1'b1;
          strobe.rotLeft  = 1'b1;
          strobe.rotThru  = 1'b1;
          strobe.writeAcc = 1'b1;
        end
        UN_RORC: begin strobe.rotate = 1'b1; strobe.rotThru = 1'b1; strobe.writeAcc = 1'b1; end
        UN_INV:  begin strobe.complement = 1'b1; strobe.writeAcc = 1'b1; end
        UN_SETC: strobe.setCarry = 1'b1;
        UN_FLPC: strobe.flipCarry = 1'b1;
        UN_NOP:  strobe = '0;
        default: strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] resAcc,
  output logic [3:0]        resFlags
);

  localparam int HALF_W = DATA_W / 2;

  logic              carryBit;
  logic [DATA_W:0]   wideSum;
  logic [HALF_W:0]   lowSum;
  logic [DATA_W:0]   cinWide;
  logic [HALF_W:0]   cinLow;
  logic [DATA_W-1:0] andVec;
  logic [DATA_W-1:0] xorVec;
  logic [DATA_W-1:0] orVec;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] rotRes;
  logic              rotOut;
  logic              rotFill;
  logic              isLogic;

  assign carryBit = strobe.carryIn & flagsIn[FLAG_C];
  assign cinWide  = {{DATA_W{1'b0}}, carryBit};
  assign cinLow   = {{HALF_W{1'b0}}, carryBit};

  always_comb begin
    if (strobe.subtract) begin
      wideSum = {1'b0, accIn} - {1'b0, operand} - cinWide;
      lowSum  = {1'b0, accIn[HALF_W-1:0]} - {1'b0, operand[HALF_W-1:0]} - cinLow;
    end else begin
      wideSum = {1'b0, accIn} + {1'b0, operand} + cinWide;
      lowSum  = {1'b0, accIn[HALF_W-1:0]} + {1'b0, operand[HALF_W-1:0]} + cinLow;
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_bitLogic
    assign andVec[b] = accIn[b] & operand[b];
    assign xorVec[b] = accIn[b] ^ operand[b];
    assign orVec[b]  = accIn[b] | operand[b];
  end

  assign isLogic  = strobe.logicAnd | strobe.logicXor | strobe.logicOr;
  assign logicRes = strobe.logicAnd ? andVec : (strobe.logicXor ? xorVec : orVec);

  always_comb begin
    if (strobe.rotLeft) begin
      rotOut  = accIn[DATA_W-1];
      rotFill = strobe.rotThru ? flagsIn[FLAG_C] : accIn[DATA_W-1];
      rotRes  = {accIn[DATA_W-2:0], rotFill};
    end else begin
      rotOut  = accIn[0];
      rotFill = strobe.rotThru ? flagsIn[FLAG_C] : accIn[0];
      rotRes  = {rotFill, accIn[DATA_W-1:1]};
    end
  end

  always_comb begin
    resAcc   = accIn;
    resFlags = flagsIn;
    if (strobe.arith) begin
      resAcc           = wideSum[DATA_W-1:0];
      resFlags[FLAG_Z] = (wideSum[DATA_W-1:0] == '0);
      resFlags[FLAG_N] = strobe.subtract;
      resFlags[FLAG_H] = lowSum[HALF_W];
      resFlags[FLAG_C] = wideSum[DATA_W];
    end else if (isLogic) begin
      resAcc           = logicRes;
      resFlags[FLAG_Z] = (logicRes == '0);
      resFlags[FLAG_N] = 1'b0;
      resFlags[FLAG_H] = strobe.logicAnd;
      resFlags[FLAG_C] = 1'b0;
    end else if (strobe.rotate) begin
      resAcc   = rotRes;
      resFlags = {3'b000, rotOut};
    end else if (strobe.complement) begin
      resAcc           = ~accIn;
      resFlags[FLAG_N] = 1'b1;
      resFlags[FLAG_H] = 1'b1;
    end else if (strobe.setCarry) begin
      resFlags[FLAG_N] = 1'b0;
      resFlags[FLAG_H] = 1'b0;
      resFlags[FLAG_C] = 1'b1;
    end else if (strobe.flipCarry) begin
      resFlags[FLAG_N] = 1'b0;
      resFlags[FLAG_H] = 1'b0;
      resFlags[FLAG_C] = ~flagsIn[FLAG_C];
    end
  end

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              isUnary,
  input  logic [2:0]        funcSel,
  input  logic [2:0]        unarySel,
  input  logic              useImm,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] regOperand,
  input  logic [DATA_W-1:0] immOperand,
  input  logic [3:0]        flagsIn,
  output logic              outValid,
  output logic [DATA_W-1:0] accOut,
  output logic              accWrEn,
  output logic [3:0]        flagsOut
);

  aluStrobe_t        strobe;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] nextAcc;
  logic [3:0]        nextFlags;

  assign operand = useImm ? immOperand : regOperand;

  alu_ctrl u_ctrl (
    .isUnary  (isUnary),
    .funcSel  (funcSel),
    .unarySel (unarySel),
    .strobe   (strobe)
  );

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobe   (strobe),
    .accIn    (accIn),
    .operand  (operand),
    .flagsIn  (flagsIn),
    .resAcc   (nextAcc),
    .resFlags (nextFlags)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      accOut   <= '0;
      accWrEn  <= 1'b0;
      flagsOut <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        accOut   <= nextAcc;
        accWrEn  <= strobe.writeAcc;
        flagsOut <= nextFlags;
      end else begin
        accWrEn  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              isUnary,
  input logic [2:0]        funcSel,
  input logic [2:0]        unarySel,
  input logic [DATA_W-1:0] accIn,
  input logic [3:0]        flagsIn,
  input logic              outValid,
  input logic [DATA_W-1:0] accOut,
  input logic              accWrEn,
  input logic [3:0]        flagsOut
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid)); // R1

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isUnary && funcSel == 3'd7) |=> (outValid && !accWrEn)); // R3

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isUnary) |=> (flagsOut[3] == (accOut == '0))); // R5

  AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isUnary && funcSel >= 3'd4 && funcSel <= 3'd6) |=> !flagsOut[0]); // R7

  AST_ROT_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isUnary && unarySel <= 3'd3) |=> (flagsOut[3:1] == 3'b000 && accWrEn)); // R10

  AST_SETC: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isUnary && unarySel == 3'd5) |=> (flagsOut[0] && !flagsOut[2] && !accWrEn)); // R12

  AST_NOP_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isUnary && unarySel == 3'd7) |=>
      (flagsOut == $past(flagsIn) && accOut == $past(accIn) && !accWrEn)); // R13

endmodule

bind acc_alu_unit alu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .isUnary  (isUnary),
  .funcSel  (funcSel),
  .unarySel (unarySel),
  .accIn    (accIn),
  .flagsIn  (flagsIn),
  .outValid (outValid),
  .accOut   (accOut),
  .accWrEn  (accWrEn),
  .flagsOut (flagsOut)
);

// File: tb/sim_acc_alu_unit.sv
`timescale 1ns/1ps
module sim_acc_alu_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       isUnary = 1'b0;
  logic [2:0] funcSel = '0;
  logic [2:0] unarySel = '0;
  logic       useImm = 1'b0;
  logic [7:0] accIn = '0;
  logic [7:0] regOperand = '0;
  logic [7:0] immOperand = '0;
  logic [3:0] flagsIn = '0;
  logic       outValid;
  logic [7:0] accOut;
  logic       accWrEn;
  logic [3:0] flagsOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [12:0] exp;
    string       tag;
  } expItem_t;

  expItem_t sb[$];

  always #2.5 clk = ~clk;

  acc_alu_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .isUnary(isUnary),
    .funcSel(funcSel), .unarySel(unarySel), .useImm(useImm), .accIn(accIn),
    .regOperand(regOperand), .immOperand(immOperand), .flagsIn(flagsIn),
    .outValid(outValid), .accOut(accOut), .accWrEn(accWrEn), .flagsOut(flagsOut)
  );

  // Reference from the requirements: returns {wr, acc[7:0], Z, N, H, C}
  function automatic logic [12:0] model(bit un, int fn, int us, int a, int b, logic [3:0] f);
    int r = a;
    int c = f[0];
    int z = f[3], n = f[2], h = f[1], cy = f[0];
    int cin;
    bit wr = 0;
    if (!un) begin
      case (fn)
        0, 1: begin
          cin = (fn == 1) ? c : 0;
          r = a + b + cin;
          h = ((a % 16) + (b % 16) + cin) > 15;
          cy = r > 255; n = 0; r = r % 256;
        end
        2, 3, 7: begin
          cin = (fn == 3) ? c : 0;
          r = a - b - cin;
          h = (a % 16) < ((b % 16) + cin);
          cy = r < 0; n = 1; r = (r + 512) % 256;
        end
        4: begin r = a & b; n = 0; h = 1; cy = 0; end
        5: begin r = a ^ b; n = 0; h = 0; cy = 0; end
        default: begin r = a | b; n = 0; h = 0; cy = 0; end
      endcase
      z = (r == 0);
      wr = (fn != 7);
    end else begin
      case (us)
        0: begin cy = a / 128; r = (a * 2) % 256 + cy; end
        1: begin cy = a % 2; r = a / 2 + cy * 128; end
        2: begin cy = a / 128; r = (a * 2) % 256 + c; end
        3: begin cy = a % 2; r = a / 2 + c * 128; end
        4: begin r = 255 - a; n = 1; h = 1; end
        5: begin n = 0; h = 0; cy = 1; end
        6: begin n = 0; h = 0; cy = (c == 0); end
        default: ;
      endcase
      if (us <= 3) begin z = 0; n = 0; h = 0; end
      wr = (us <= 4);
    end
    return {wr, r[7:0], z[0], n[0], h[0], cy[0]};
  endfunction

  task automatic send(bit un, int fn, int us, bit imm, int a, int rb, int ib,
                      logic [3:0] f, string tag);
    expItem_t it;
    @(negedge clk);
    inValid    = 1'b1;
    isUnary    = un;
    funcSel    = fn[2:0];
    unarySel   = us[2:0];
    useImm     = imm;
    accIn      = a[7:0];
    regOperand = rb[7:0];
    immOperand = ib[7:0];
    flagsIn    = f;
    it.exp = model(un, fn, us, a, imm ? ib : rb, f);
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Monitor: compares one registered result per cycle against the scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      expItem_t it;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL unexpected result: got %h expected none", {accWrEn, accOut, flagsOut});
      end else begin
        it = sb.pop_front();
        if ({accWrEn, accOut, flagsOut} !== it.exp) begin
          errors++;
          $display("FAIL %s: got wr=%b acc=%h f=%b expected wr=%b acc=%h f=%b",
                   it.tag, accWrEn, accOut, flagsOut, it.exp[12], it.exp[11:4], it.exp[3:0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++; // R1 reset state
    if ({outValid, accWrEn, accOut, flagsOut} !== 14'd0) begin
      errors++;
      $display("FAIL R1 reset: got %h expected 0", {outValid, accWrEn, accOut, flagsOut});
    end

    send(0, 0, 0, 0, 8'h12, 8'h34, 0, 4'h0, "R2 add");
    send(0, 0, 0, 0, 8'h0F, 8'h01, 0, 4'h1, "R6 add half carry, R4 plain add ignores C");
    send(0, 0, 0, 0, 8'hFF, 8'h01, 0, 4'h0, "R6 add wrap");
    send(0, 1, 0, 0, 8'hFF, 8'h00, 0, 4'h1, "R4 adc carry in");
    send(0, 1, 0, 0, 8'h0E, 8'h01, 0, 4'h1, "R4 adc half carry");
    send(0, 2, 0, 0, 8'h10, 8'h01, 0, 4'h0, "R6 sub half borrow");
    send(0, 2, 0, 0, 8'h42, 8'h42, 0, 4'h0, "R5 sub zero");
    send(0, 3, 0, 0, 8'h00, 8'h00, 0, 4'h1, "R4 sbc borrow in");
    send(0, 3, 0, 0, 8'h05, 8'h03, 0, 4'h0, "R4 sbc without carry");
    send(0, 4, 0, 0, 8'hF0, 8'h0F, 0, 4'hF, "R7 and zero");
    send(0, 5, 0, 0, 8'hAA, 8'hAA, 0, 4'hF, "R7 xor");
    send(0, 6, 0, 0, 8'hA0, 8'h05, 0, 4'hF, "R7 or");
    send(0, 7, 0, 0, 8'h20, 8'h30, 0, 4'h0, "R3 compare borrow");
    send(0, 7, 0, 0, 8'h55, 8'h55, 0, 4'h1, "R3 compare equal");
    send(0, 0, 0, 1, 8'h01, 8'h80, 8'h02, 4'h0, "R8 immediate operand");
    send(0, 0, 0, 0, 8'h01, 8'h80, 8'h02, 4'h0, "R8 register operand");
    send(1, 0, 0, 0, 8'h81, 0, 0, 4'hE, "R9 rotate left");
    send(1, 1, 1, 0, 8'h01, 0, 0, 4'hE, "R9 rotate right");
    send(1, 0, 2, 0, 8'h80, 0, 0, 4'h0, "R10 rotate left thru carry");
    send(1, 0, 2, 0, 8'h01, 0, 0, 4'h1, "R10 rotate left thru carry set");
    send(1, 0, 3, 0, 8'h01, 0, 0, 4'h0, "R10 rotate right thru carry");
    send(1, 0, 3, 0, 8'h02, 0, 0, 4'h1, "R10 rotate right thru carry set");
    send(1, 0, 4, 0, 8'h3C, 0, 0, 4'h9, "R11 complement");
    send(1, 0, 5, 0, 8'h77, 0, 0, 4'hE, "R12 set carry");
    send(1, 0, 6, 0, 8'h77, 0, 0, 4'h9, "R12 flip carry");
    send(1, 0, 6, 0, 8'h77, 0, 0, 4'h0, "R12 flip carry clear");
    send(1, 0, 7, 0, 8'h5A, 0, 0, 4'hB, "R13 no-op");
    idle();
    idle();
    checks++; // R1 idle gap
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle: got outValid=%b expected 0", outValid);
    end

    foreach (sb[i]) ; // keep order; sweep follows
    for (int fn = 0; fn < 8; fn++) begin
      for (int k = 0; k < 4; k++) begin
        int a = (k * 77 + fn * 13 + 15) % 256;
        int b = (k * 91 + 128) % 256;
        send(0, fn, 0, k[0], a, b, 255 - b, {3'b000, k[1]}, "R2 sweep");
      end
    end
    idle();
    idle();
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R1 results missing: got %0d pending expected 0", sb.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule